// File: doc/BRIEF.md
# Dual-Port Same-Address Collision Alert

This block watches the access streams of the two ports of a synchronous dual-port RAM that share one clock. Each port presents an enable, a write select and an address, and these are registered on every rising edge. When both ports are enabled and their registered addresses match on the same edge, the block decides from the two access kinds which port's data may be unreliable. It then raises an active-low alert for that port.

A port is alerted when the opposite port writes the shared address. Two reads at the same address alert nobody. A read against a write alerts only the reader, because the write itself lands correctly. Two writes alert both ports. An alert appears a fixed two edges after the colliding access is registered, stays low for one cycle and then releases without any action from outside. A collision registered on the edge right after one that raised an alert is dropped, so a sustained stream of colliding accesses makes the alert toggle on alternate cycles.

The block only observes. It does not arbitrate data and does not contain the memory array.

Top module: `dp_collision_det`

## Requirements
- R1: After reset, and while rst_ni is low, both col_a_no and col_b_no are high.
- R2: When both ports are enabled, both read (wr=0) and the addresses are equal, neither alert goes low.
- R3: When both ports are enabled, the addresses are equal, and exactly one port writes (wr=1) while the other reads, only the reading port's alert goes low.
- R4: When both ports are enabled, both write and the addresses are equal, both alerts go low.
- R5: No alert goes low when the addresses differ or when either enable is low (en=0), whatever the write selects are.
- R6: For an access sampled on rising edge N that raises an alert, the alert output is low after edge N+2 and no earlier.
- R7: An alert stays low for exactly one cycle. It is high again after the next edge, with no external clear.
- R8: If a collision that raised an alert on a port is followed on the very next edge by another collision for that port, the second one raises no alert. A third consecutive collision raises the alert normally.
- R9: With a same-address collision registered on every edge, each affected port's alert is low on alternate cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_a_i | input | 1 | Port A access enable, active high |
| wr_a_i | input | 1 | Port A write select (1 = write, 0 = read) |
| addr_a_i | input | ADDR_W | Port A address |
| en_b_i | input | 1 | Port B access enable, active high |
| wr_b_i | input | 1 | Port B write select (1 = write, 0 = read) |
| addr_b_i | input | ADDR_W | Port B address |
| col_a_no | output | 1 | Port A collision alert, active low |
| col_b_no | output | 1 | Port B collision alert, active low |

## Verification
The bench aims at the flag choice for each pairing of access kinds. A design that mixed up the reader and the writer would alert the port whose write succeeded and leave the reader silent. It also targets the exact latency: an off-by-one pipeline would move the low pulse by a cycle, and the per-cycle comparison catches that. It drives back-to-back and sustained collisions, where missing suppression would hold the alert low across several cycles instead of toggling it. It also sends matching addresses with one enable off and near-miss addresses, so that a decode which ignores the enables or compares only part of the address would raise alerts that should not appear.

// File: rtl/cd_pkg.sv
`timescale 1ns/1ps
package cd_pkg;
  localparam int unsigned NUM_PORTS = 2;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/cd_access_reg.sv
`timescale 1ns/1ps
module cd_access_reg
  import cd_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [ADDR_W-1:0] addr_o
);
  acc_kind_e kind_d;

  always_comb begin
    if (!en_i)     kind_d = ACC_IDLE;
    else if (wr_i) kind_d = ACC_WRITE;
    else           kind_d = ACC_READ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o <= ACC_IDLE;
      addr_o <= '0;
    end else begin
      kind_o <= kind_d;
      addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/cd_classify.sv
`timescale 1ns/1ps
module cd_classify
  import cd_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  acc_kind_e             kind_a_i,
  input  logic [ADDR_W-1:0]     addr_a_i,
  input  acc_kind_e             kind_b_i,
  input  logic [ADDR_W-1:0]     addr_b_i,
  output logic [NUM_PORTS-1:0]  hit_o
);
  logic overlap;

  assign overlap = (kind_a_i != ACC_IDLE) && (kind_b_i != ACC_IDLE) &&
                   (addr_a_i == addr_b_i);

  // A port's data is suspect only when the opposite port writes.
  assign hit_o[0] = overlap && (kind_b_i == ACC_WRITE);
  assign hit_o[1] = overlap && (kind_a_i == ACC_WRITE);
endmodule

// File: rtl/cd_alert_pipe.sv
`timescale 1ns/1ps
module cd_alert_pipe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic pend_o,
  output logic col_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      col_no <= 1'b1;
    end else begin
      // a hit right after a flagged one is dropped
      pend_o <= hit_i & ~pend_o;
      col_no <= ~pend_o;
    end
  end

  assert_self_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !col_no |=> col_no);

  assert_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |=> !col_no);

  assert_no_early_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_o |=> col_no);
endmodule

// File: rtl/dp_collision_det.sv
`timescale 1ns/1ps
module dp_collision_det
  import cd_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_a_i,
  input  logic              wr_a_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic              en_b_i,
  input  logic              wr_b_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  output logic              col_a_no,
  output logic              col_b_no
);
  logic [NUM_PORTS-1:0]  en_v, wr_v, hit, pend, col_n;
  logic [ADDR_W-1:0]     addr_in [NUM_PORTS];
  logic [ADDR_W-1:0]     addr_q  [NUM_PORTS];
  acc_kind_e             kind_q  [NUM_PORTS];

  assign en_v       = {en_b_i, en_a_i};
  assign wr_v       = {wr_b_i, wr_a_i};
  assign addr_in[0] = addr_a_i;
  assign addr_in[1] = addr_b_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    cd_access_reg #(.ADDR_W(ADDR_W)) i_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_v[p]),
      .wr_i   (wr_v[p]),
      .addr_i (addr_in[p]),
      .kind_o (kind_q[p]),
      .addr_o (addr_q[p])
    );

    cd_alert_pipe i_pipe (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_i  (hit[p]),
      .pend_o (pend[p]),
      .col_no (col_n[p])
    );
  end

  cd_classify #(.ADDR_W(ADDR_W)) i_cls (
    .kind_a_i (kind_q[0]),
    .addr_a_i (addr_q[0]),
    .kind_b_i (kind_q[1]),
    .addr_b_i (addr_q[1]),
    .hit_o    (hit)
  );

  assign col_a_no = col_n[0];
  assign col_b_no = col_n[1];

  logic same_q;
  assign same_q = (addr_q[0] == addr_q[1]);

  assert_rd_rd_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q[0] == ACC_READ && kind_q[1] == ACC_READ && same_q) |=> (pend == '0));

  assert_writer_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q[0] == ACC_WRITE && kind_q[1] == ACC_READ && same_q) |=> !pend[0]);

  assert_both_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q[0] == ACC_WRITE && kind_q[1] == ACC_WRITE && same_q && pend == '0)
      |=> (pend == '1));

  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q[0] == ACC_IDLE || kind_q[1] == ACC_IDLE) |=> (pend == '0));
endmodule

// File: tb/test_dp_collision_det.sv
`timescale 1ns/1ps
module test_dp_collision_det;
  localparam int unsigned AW = 17;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_a, wr_a, en_b, wr_b;
  logic [AW-1:0] addr_a, addr_b;
  logic          col_a_no, col_b_no;

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string req = "R1";

  // history of raised flags per port: [0] newest edge
  bit [2:0] fa, fb;

  always #4 clk_i = ~clk_i;

  dp_collision_det #(.ADDR_W(AW)) i_dp_collision_det (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_a_i(en_a), .wr_a_i(wr_a), .addr_a_i(addr_a),
    .en_b_i(en_b), .wr_b_i(wr_b), .addr_b_i(addr_b),
    .col_a_no(col_a_no), .col_b_no(col_b_no)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fa = '0;
      fb = '0;
    end else begin
      bit same, ra, rb;
      same = en_a && en_b && (addr_a == addr_b);
      ra = same && wr_b && !fa[0];
      rb = same && wr_a && !fb[0];
      fa = {fa[1:0], ra};
      fb = {fb[1:0], rb};
    end
  end

  task automatic check(string tag, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check(req, "col_a_no", col_a_no, ~fa[2]);
      check(req, "col_b_no", col_b_no, ~fb[2]);
    end
  end

  task automatic drive(bit ea, bit wa, int aa, bit eb, bit wb, int ab, int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      en_a = ea; wr_a = wa; addr_a = AW'(aa);
      en_b = eb; wr_b = wb; addr_b = AW'(ab);
    end
  endtask

  task automatic idle(int n);
    drive(0, 0, 0, 0, 0, 0, n);
  endtask

  initial begin
    en_a = 0; wr_a = 0; addr_a = '0;
    en_b = 0; wr_b = 0; addr_b = '0;
    repeat (3) @(negedge clk_i);
    check("R1", "col_a_no in reset", col_a_no, 1'b1);
    check("R1", "col_b_no in reset", col_b_no, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "col_a_no after reset", col_a_no, 1'b1);
    check("R1", "col_b_no after reset", col_b_no, 1'b1);

    req = "R2"; drive(1, 0, 'h1FFFE, 1, 0, 'h1FFFE, 3); idle(4);
    req = "R3"; drive(1, 1, 'h00010, 1, 0, 'h00010);    idle(4);
    req = "R3"; drive(1, 0, 'h1FFFF, 1, 1, 'h1FFFF);    idle(4);
    req = "R4"; drive(1, 1, 'h00123, 1, 1, 'h00123);    idle(4);
    req = "R5"; drive(1, 1, 'h00123, 1, 1, 'h00122, 2);
                drive(0, 1, 'h00050, 1, 1, 'h00050, 2);
                drive(1, 1, 'h00050, 0, 1, 'h00050, 2);
                drive(1, 1, 'h10000, 1, 1, 'h00000, 2); idle(4);

    // single alert: low after edge N+2, high after N+3
    req = "R6";
    drive(1, 1, 'h00777, 1, 1, 'h00777);
    idle(1);
    @(posedge clk_i); #1;
    check("R6", "col_a_no one edge after sample", col_a_no, 1'b1);
    @(negedge clk_i); en_a = 0; en_b = 0;
    @(posedge clk_i); #1;
    check("R6", "col_a_no two edges after sample", col_a_no, 1'b0);
    check("R6", "col_b_no two edges after sample", col_b_no, 1'b0);
    @(posedge clk_i); #1;
    check("R7", "col_a_no self clear", col_a_no, 1'b1);
    check("R7", "col_b_no self clear", col_b_no, 1'b1);
    req = "R7"; idle(4);

    req = "R8"; drive(1, 0, 'h00200, 1, 1, 'h00200, 2); idle(5);
    req = "R8"; drive(1, 1, 'h00201, 1, 0, 'h00201, 3); idle(5);
    req = "R9"; drive(1, 1, 'h0ABCD, 1, 1, 'h0ABCD, 12); idle(5);
    req = "R9"; drive(1, 1, 'h00300, 1, 0, 'h00300, 9); idle(5);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule